// File: doc/BRIEF.md
# Indirect MAC Configuration Register Window

This block connects a 32-bit host register bus to a small bank of 16-bit MAC configuration registers that the host cannot address directly. The host sees four words: an address window, a data window, a status word and one reserved word. Every access to the bank goes through the two windows. The write flag in the address-window word picks the direction.

To store a value, the host first loads the data window. It then writes the address window with the flag set, and the addressed register takes the data-window value. To fetch a value, the host writes the address window with the flag clear, waits for the settle interval to end, and reads the data window. A settle timer starts on every accepted address-window write. While the timer runs the block reports busy, and it drops any further window write.

The bank holds a mode register, a receive/transmit control word and three station-address registers. Their contents drive the MAC datapath as plain level outputs.

Top module: `mac_reg_window`

## Requirements
- R1: After reset the mode register reads 0x0008, so only flow control is enabled. The control register, all three station registers and the data window read zero, and busy is low.
- R2: Host word 0 is the address window and host word 1 is the data window. Bit 15 of an address-window word is the write flag and bits 4:0 are the internal address. A flagged write that is accepted copies the data window into the addressed register, and the register outputs show the new value one cycle later. The internal addresses are: mode 0x00, control 0x01, station registers 0x04, 0x05 and 0x06.
- R3: An accepted address-window write with the flag clear loads the addressed register into the data window at the end of the settle interval. Until that point, the data window keeps its previous value.
- R4: Every accepted address-window write makes busy high for exactly SETTLE_CYCLES cycles, starting in the next cycle. Bit 0 of host word 2 reads the same busy state.
- R5: An address-window write that arrives while busy is high is ignored. It changes no internal register, starts no fetch and does not extend the busy time.
- R6: A data-window write that arrives while busy is high is ignored.
- R7: A fetch from an unimplemented internal address returns zero. A flagged write to one changes no implemented register.
- R8: The station registers form station_addr in this order: register 0x04 is bits 47:32, 0x05 is bits 31:16 and 0x06 is bits 15:0. The first address byte is therefore bits 47:40, the high half of register 0x04.
- R9: In the mode register, bit 0 enables receive, bit 1 enables transmit, bit 2 selects gigabit operation and bit 3 enables flow control. Bits 15:4 ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 2 | Host word select: 0 address window, 1 data window, 2 status, 3 reserved |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the word selected by host_addr (combinational) |
| mode_rx_en | output | 1 | Receive enable from the mode register |
| mode_tx_en | output | 1 | Transmit enable from the mode register |
| mode_gbit_en | output | 1 | Gigabit mode select from the mode register |
| mode_fc_en | output | 1 | Flow-control enable from the mode register |
| rxtx_ctl | output | 16 | Receive/transmit control word |
| station_addr | output | 48 | Station address, first byte in bits 47:40 |
| busy | output | 1 | Settle interval in progress |

## Verification
A table of store-then-fetch pairs exercises the main path. The table covers every implemented address, two unimplemented addresses, and mode-register values whose upper bits are set. A wrong address decode, a missing read mask or a wrong field layout therefore appears as a mismatched read-back.

Directed sequences then target timing. One samples the data window in the middle of a fetch, which shows whether the value is captured at the start or at the end of the settle interval. Another counts the busy cycles. A third sends a data write and a flagged address write during busy, and then checks both the data window and the total busy time, which separates "dropped" from "queued" and "restarted". Distinct byte values in the three station registers expose any swap of halves or registers on station_addr.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

    localparam int IREG_W       = 16;
    localparam int HOST_W       = 32;
    localparam int WR_FLAG_BIT  = 15;
    localparam int STA_REGS     = 3;

    localparam int IA_MODE      = 0;
    localparam int IA_CTL       = 1;
    localparam int IA_STA_BASE  = 4;

    typedef enum logic [1:0] {
        HREG_ADDR = 2'd0,
        HREG_DATA = 2'd1,
        HREG_STAT = 2'd2,
        HREG_RSVD = 2'd3
    } host_reg_e;

    typedef struct packed {
        logic fc_en;
        logic gbit_en;
        logic tx_en;
        logic rx_en;
    } mode_t;

    localparam mode_t MODE_RESET = '{fc_en: 1'b1, gbit_en: 1'b0, tx_en: 1'b0, rx_en: 1'b0};

    typedef struct packed {
        logic        is_wr;
        logic [14:0] addr;
    } win_cmd_t;

    function automatic logic [IREG_W-1:0] mode_to_word(input mode_t m);
        return {{(IREG_W-4){1'b0}}, m};
    endfunction

    function automatic mode_t word_to_mode(input logic [IREG_W-1:0] w);
        return mode_t'(w[3:0]);
    endfunction

endpackage

// File: rtl/mrw_settle_timer.sv
module mrw_settle_timer #(
    parameter int SETTLE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start && cnt_q == '0) begin
            cnt_q <= CW'(SETTLE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/mrw_reg_bank.sv
module mrw_reg_bank
    import mrw_pkg::*;
#(
    parameter int IADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wen,
    input  logic [IADDR_W-1:0] waddr,
    input  logic [IREG_W-1:0]  wdata,
    input  logic [IADDR_W-1:0] raddr,
    output logic [IREG_W-1:0]  rdata,
    output mode_t              mode,
    output logic [IREG_W-1:0]  ctl,
    output logic [IREG_W*STA_REGS-1:0] station
);
    mode_t             mode_q;
    logic [IREG_W-1:0] ctl_q;
    logic [IREG_W-1:0] sta_q [STA_REGS];
    logic [STA_REGS-1:0] sta_wr_hit;
    logic [STA_REGS-1:0] sta_rd_hit;

    genvar g;
    generate
        for (g = 0; g < STA_REGS; g++) begin : g_sta_dec
            assign sta_wr_hit[g] = wen && (waddr == IADDR_W'(IA_STA_BASE + g));
            assign sta_rd_hit[g] = (raddr == IADDR_W'(IA_STA_BASE + g));
            assign station[IREG_W*(STA_REGS-g)-1 -: IREG_W] = sta_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
            ctl_q  <= '0;
            for (int i = 0; i < STA_REGS; i++) begin
                sta_q[i] <= '0;
            end
        end else begin
            if (wen && waddr == IADDR_W'(IA_MODE)) begin
                mode_q <= word_to_mode(wdata);
            end
            if (wen && waddr == IADDR_W'(IA_CTL)) begin
                ctl_q <= wdata;
            end
            for (int i = 0; i < STA_REGS; i++) begin
                if (sta_wr_hit[i]) begin
                    sta_q[i] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr == IADDR_W'(IA_MODE)) begin
            rdata = mode_to_word(mode_q);
        end
        if (raddr == IADDR_W'(IA_CTL)) begin
            rdata = ctl_q;
        end
        for (int i = 0; i < STA_REGS; i++) begin
            if (sta_rd_hit[i]) begin
                rdata = sta_q[i];
            end
        end
    end

    assign mode = mode_q;
    assign ctl  = ctl_q;

endmodule

// File: rtl/mrw_host_if.sv
module mrw_host_if
    import mrw_pkg::*;
#(
    parameter int IADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [1:0]         host_addr,
    input  logic [HOST_W-1:0]  host_wdata,
    output logic [HOST_W-1:0]  host_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic [IREG_W-1:0]  bank_rdata,
    output logic               start,
    output logic               bank_wen,
    output logic [IADDR_W-1:0] bank_waddr,
    output logic [IREG_W-1:0]  bank_wdata,
    output logic [IADDR_W-1:0] bank_raddr,
    output logic [IREG_W-1:0]  data_win
);
    win_cmd_t          cmd_q;
    logic [IREG_W-1:0] data_q;
    logic              rd_pend_q;
    logic              addr_acc;
    logic              data_acc;
    host_reg_e         sel;
    logic              unused_hi;

    assign sel       = host_reg_e'(host_addr);
    assign addr_acc  = host_wr && sel == HREG_ADDR && !busy;
    assign data_acc  = host_wr && sel == HREG_DATA && !busy;
    assign unused_hi = ^host_wdata[HOST_W-1:IREG_W];

    assign start      = addr_acc;
    assign bank_wen   = addr_acc && host_wdata[WR_FLAG_BIT];
    assign bank_waddr = host_wdata[IADDR_W-1:0];
    assign bank_wdata = data_q;
    assign bank_raddr = cmd_q.addr[IADDR_W-1:0];
    assign data_win   = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            data_q    <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            if (addr_acc) begin
                cmd_q     <= win_cmd_t'(host_wdata[IREG_W-1:0]);
                rd_pend_q <= !host_wdata[WR_FLAG_BIT];
            end else if (done && rd_pend_q) begin
                rd_pend_q <= 1'b0;
            end
            if (data_acc) begin
                data_q <= host_wdata[IREG_W-1:0];
            end else if (done && rd_pend_q) begin
                data_q <= bank_rdata;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (sel)
            HREG_ADDR: host_rdata = {{(HOST_W-IREG_W){1'b0}}, cmd_q};
            HREG_DATA: host_rdata = {{(HOST_W-IREG_W){1'b0}}, data_q};
            HREG_STAT: host_rdata = {{(HOST_W-1){1'b0}}, busy};
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mac_reg_window.sv
module mac_reg_window
    import mrw_pkg::*;
#(
    parameter int IADDR_W       = 5,
    parameter int SETTLE_CYCLES = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mode_rx_en,
    output logic        mode_tx_en,
    output logic        mode_gbit_en,
    output logic        mode_fc_en,
    output logic [15:0] rxtx_ctl,
    output logic [47:0] station_addr,
    output logic        busy
);
    logic               start;
    logic               done;
    logic               bank_wen;
    logic [IADDR_W-1:0] bank_waddr;
    logic [IADDR_W-1:0] bank_raddr;
    logic [IREG_W-1:0]  bank_wdata;
    logic [IREG_W-1:0]  bank_rdata;
    logic [IREG_W-1:0]  data_win;
    mode_t              mode;

    mrw_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    mrw_host_if #(.IADDR_W(IADDR_W)) u_host (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done),
        .bank_rdata (bank_rdata),
        .start      (start),
        .bank_wen   (bank_wen),
        .bank_waddr (bank_waddr),
        .bank_wdata (bank_wdata),
        .bank_raddr (bank_raddr),
        .data_win   (data_win)
    );

    mrw_reg_bank #(.IADDR_W(IADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wen     (bank_wen),
        .waddr   (bank_waddr),
        .wdata   (bank_wdata),
        .raddr   (bank_raddr),
        .rdata   (bank_rdata),
        .mode    (mode),
        .ctl     (rxtx_ctl),
        .station (station_addr)
    );

    assign mode_rx_en   = mode.rx_en;
    assign mode_tx_en   = mode.tx_en;
    assign mode_gbit_en = mode.gbit_en;
    assign mode_fc_en   = mode.fc_en;

endmodule

// File: rtl/mrw_checker.sv
module mrw_checker #(
    parameter int IADDR_W       = 5,
    parameter int SETTLE_CYCLES = 100
) (
    input logic        clk,
    input logic        rst,
    input logic        host_wr,
    input logic [1:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        busy,
    input logic        mode_rx_en,
    input logic        mode_tx_en,
    input logic        mode_gbit_en,
    input logic        mode_fc_en,
    input logic [15:0] rxtx_ctl,
    input logic [47:0] station_addr,
    input logic [15:0] data_win
);
    localparam int RW = $clog2(SETTLE_CYCLES + 1) + 1;

    logic [RW-1:0] run_q;
    logic          addr_wr;
    logic [3:0]    mode_bits;

    assign addr_wr   = host_wr && host_addr == 2'd0;
    assign mode_bits = {mode_fc_en, mode_gbit_en, mode_tx_en, mode_rx_en};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R1: mode leaves reset with only flow control set
    p_mode_reset_r1: assert property (@(posedge clk)
        rst |=> (mode_bits == 4'b1000 && rxtx_ctl == 16'h0 && !busy));

    // R2: flagged write to control commits the data window
    p_ctl_commit_r2: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !busy && host_wdata[15] && host_wdata[IADDR_W-1:0] == IADDR_W'(1))
        |=> rxtx_ctl == $past(data_win));

    // R4: accepted window write raises busy
    p_busy_start_r4: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !busy) |=> busy);

    // R4: busy lasted exactly the settle interval
    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> run_q == RW'(SETTLE_CYCLES));

    // R5: address write during busy leaves the bank alone
    p_held_off_r5: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && busy) |=> ($stable(rxtx_ctl) && $stable(station_addr) && $stable(mode_bits)));

    // R6: data window does not move inside the settle interval
    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(data_win));

endmodule

bind mac_reg_window mrw_checker #(
    .IADDR_W       (IADDR_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_mrw_checker (
    .clk          (clk),
    .rst          (rst),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .busy         (busy),
    .mode_rx_en   (mode_rx_en),
    .mode_tx_en   (mode_tx_en),
    .mode_gbit_en (mode_gbit_en),
    .mode_fc_en   (mode_fc_en),
    .rxtx_ctl     (rxtx_ctl),
    .station_addr (station_addr),
    .data_win     (data_win)
);

// File: tb/mac_reg_window_bench.sv
module mac_reg_window_bench;
    localparam int SETTLE = 100;
    localparam int NVEC   = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mode_rx_en, mode_tx_en, mode_gbit_en, mode_fc_en;
    logic [15:0] rxtx_ctl;
    logic [47:0] station_addr;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mac_reg_window #(.IADDR_W(5), .SETTLE_CYCLES(SETTLE)) u_mac_reg_window (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .mode_rx_en   (mode_rx_en),
        .mode_tx_en   (mode_tx_en),
        .mode_gbit_en (mode_gbit_en),
        .mode_fc_en   (mode_fc_en),
        .rxtx_ctl     (rxtx_ctl),
        .station_addr (station_addr),
        .busy         (busy)
    );

    // {internal address, value stored, value expected on fetch}
    localparam logic [36:0] VEC [NVEC] = '{
        {5'h00, 16'h00FF, 16'h000F},
        {5'h01, 16'hA5C3, 16'hA5C3},
        {5'h04, 16'h1234, 16'h1234},
        {5'h05, 16'h5678, 16'h5678},
        {5'h06, 16'h9ABC, 16'h9ABC},
        {5'h1F, 16'hFFFF, 16'h0000},
        {5'h03, 16'hBEEF, 16'h0000},
        {5'h01, 16'h0000, 16'h0000},
        {5'h00, 16'hFFF8, 16'h0008}
    };

    task automatic check(input logic [47:0] act, input logic [47:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1;
        host_addr = a;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic store(input logic [4:0] ia, input logic [15:0] v);
        hw(2'd1, {16'h0, v});
        hw(2'd0, {16'h0, 1'b1, 10'h0, ia});
        wait_idle();
    endtask

    task automatic fetch(input logic [4:0] ia, output logic [15:0] v);
        hw(2'd0, {16'h0, 1'b0, 10'h0, ia});
        wait_idle();
        host_addr = 2'd1;
        #1;
        v = host_rdata[15:0];
    endtask

    initial begin
        logic [15:0] rv;
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check({44'h0, mode_fc_en, mode_gbit_en, mode_tx_en, mode_rx_en}, 48'h8, "R1 mode outputs");
        check({32'h0, rxtx_ctl}, 48'h0, "R1 control");
        check(station_addr, 48'h0, "R1 station");
        check({47'h0, busy}, 48'h0, "R1 busy");
        host_addr = 2'd1; #1;
        check({16'h0, host_rdata}, 48'h0, "R1 data window");
        fetch(5'h00, rv);
        check({32'h0, rv}, 48'h0008, "R1 mode fetch");

        // R2 R7 R9 table of store/fetch pairs
        for (int i = 0; i < NVEC; i++) begin
            store(VEC[i][36:32], VEC[i][31:16]);
            fetch(VEC[i][36:32], rv);
            check({32'h0, rv}, {32'h0, VEC[i][15:0]}, "R2/R7/R9 table");
        end
        // R7 unimplemented writes left implemented registers intact
        check(station_addr, 48'h123456789ABC, "R7 station untouched");

        // R9 mode bit positions
        store(5'h00, 16'h0005);
        check({44'h0, mode_fc_en, mode_gbit_en, mode_tx_en, mode_rx_en}, 48'h5, "R9 rx+gbit");
        store(5'h00, 16'h000A);
        check({44'h0, mode_fc_en, mode_gbit_en, mode_tx_en, mode_rx_en}, 48'hA, "R9 tx+fc");

        // R8 station layout
        store(5'h04, 16'hA1B2);
        store(5'h05, 16'hC3D4);
        store(5'h06, 16'hE5F6);
        check(station_addr, 48'hA1B2C3D4E5F6, "R8 station order");
        check({40'h0, station_addr[47:40]}, 48'hA1, "R8 first byte");

        // R2 output one cycle after the flagged write
        hw(2'd1, 32'h0000_7E81);
        hw(2'd0, 32'h0000_8001);
        check({32'h0, rxtx_ctl}, 48'h7E81, "R2 control updated");
        wait_idle();

        // R3 data window keeps old value until settle end
        hw(2'd1, 32'h0000_0F0F);
        hw(2'd0, 32'h0000_0004);
        host_addr = 2'd1; #1;
        check({32'h0, host_rdata[15:0]}, 48'h0F0F, "R3 old value during settle");
        wait_idle();
        host_addr = 2'd1; #1;
        check({32'h0, host_rdata[15:0]}, 48'hA1B2, "R3 fetched value");

        // R4 busy length and status bit
        hw(2'd0, 32'h0000_0001);
        host_addr = 2'd2; #1;
        check({47'h0, host_rdata[0]}, 48'h1, "R4 status bit");
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        check(48'(cnt), 48'(SETTLE), "R4 busy cycles");
        host_addr = 2'd2; #1;
        check({47'h0, host_rdata[0]}, 48'h0, "R4 status idle");

        // R5 R6 writes during busy are dropped
        store(5'h01, 16'h1111);
        hw(2'd1, 32'h0000_2222);
        hw(2'd0, 32'h0000_8004);
        hw(2'd1, 32'h0000_3333);
        hw(2'd0, 32'h0000_8001);
        host_addr = 2'd1; #1;
        check({32'h0, host_rdata[15:0]}, 48'h2222, "R6 data window held");
        repeat (SETTLE - 5) @(negedge clk);
        check({47'h0, busy}, 48'h1, "R5 busy not restarted (still busy)");
        @(negedge clk);
        check({47'h0, busy}, 48'h0, "R5 busy ends on time");
        check({32'h0, rxtx_ctl}, 48'h1111, "R5 control unchanged");
        check({32'h0, station_addr[47:32]}, 48'h2222, "R5 accepted write landed");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule